// File: doc/BRIEF.md
# DMA Burst Splitter with Outstanding-Request Cap

This block sits between a DMA engine and the address channels of an AXI initiator. The DMA engine hands it one transfer at a time as a start address, a byte count and a direction. The block cuts the transfer into AXI bursts. No burst crosses a page boundary, and no burst is longer than 256 beats. Read transfers are issued on the read address channel and write transfers on the write address channel.

A shared counter tracks how many address requests are still waiting for their data phase. When the count reaches the programmed cap, the block stops presenting new addresses. It resumes when the read-data path reports a last beat or the write-response path reports a response.

The page size (1 KB or 4 KB) and the cap (1 to 16) are sampled when a transfer is accepted. They stay fixed for the whole transfer. Start addresses and byte counts are assumed to be multiples of the beat size, which is 8 bytes by default.

Top module: `dma_burst_splitter`

## Requirements
- R1: While reset is high and in the first cycle after it, `ar_valid`, `aw_valid` and `req_ready` (with `req_valid` low) are all 0.
- R2: With `cfg_page_1k` = 0, no burst spans an address that is a multiple of 4096.
- R3: With `cfg_page_1k` = 1, no burst spans an address that is a multiple of 1024.
- R4: Each burst covers the smallest of three byte counts: the bytes left in the transfer, the bytes left to the next page boundary, and 256 beats (2048 bytes at 8-byte beats). The length output carries beats minus one. Each burst starts where the previous one ended, and the first burst starts at the request address.
- R5: A request with `req_write` = 0 produces bursts only on the AR outputs. A request with `req_write` = 1 produces bursts only on the AW outputs. The two valids are never high together.
- R6: Once a channel valid is high with its ready low, the valid, address and length stay unchanged in the next cycle.
- R7: With `cfg_limit` = N, at most N+1 address handshakes may be outstanding. At that count, both valids stay low.
- R8: The outstanding count rises by one on each address handshake. It falls by one for each of `rd_last_done` and `wr_resp_done` that is high. Events in the same cycle are netted.
- R9: `req_ready` is high only in the cycle in which the last burst of the request is handshaken. A request with `req_len` = 0 is acknowledged combinationally while the block is idle, and it produces no burst.
- R10: `cfg_page_1k` and `cfg_limit` are sampled when a request is accepted. Changes made while a transfer is in progress affect only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Transfer acknowledged (last burst issued, or zero length) |
| req_addr | input | ADDR_W | Transfer start byte address |
| req_len | input | LEN_W | Transfer byte count |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| cfg_page_1k | input | 1 | 1 = split at 1 KB, 0 = split at 4 KB |
| cfg_limit | input | 4 | Outstanding cap minus one |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | ADDR_W | Read burst address |
| ar_len | output | 8 | Read burst beats minus one |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Write burst address |
| aw_len | output | 8 | Write burst beats minus one |
| rd_last_done | input | 1 | Pulse: last read-data beat accepted |
| wr_resp_done | input | 1 | Pulse: write response accepted |

## Verification
The bench sends transfers that start just below a 4 KB page edge and just below a 1 KB page edge, plus one long enough to hit the 256-beat cap. A wrong boundary mask or a missing minimum shows up as an address or length that differs from the bench's own split.

The bench holds completions back so the block sits at the cap. It then releases one completion in the same cycle as a new handshake, and later releases a read and a write completion together. A counter that ignores netting either stalls one burst early or lets one extra burst through.

The page bit is flipped after the first burst. A design that reads the live configuration would merge the remaining bursts. The bench also stalls ready, sends a zero-length request, and tracks the acknowledge cycle. These catch an address that moves under backpressure, a spurious burst, and an acknowledge that comes early or late.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

    localparam int AXI_LEN_W     = 8;
    localparam int AXI_MAX_BEATS = 256;
    localparam int CFG_LIMIT_W   = 4;
    localparam int PAGE_SMALL    = 1024;
    localparam int PAGE_LARGE    = 4096;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } split_state_e;

    typedef struct packed {
        logic                   page_1k;
        logic [CFG_LIMIT_W-1:0] limit;
    } cfg_snap_t;

    localparam cfg_snap_t CFG_RESET = '{page_1k: 1'b0, limit: 4'd3};

    function automatic logic [31:0] umin(input logic [31:0] a, input logic [31:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/dma_burst_calc.sv
module dma_burst_calc
    import dma_split_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int BEAT_BYTES = 8
) (
    input  logic [11:0]          addr_lo,
    input  logic [LEN_W-1:0]     rem_bytes,
    input  logic                 page_1k,
    output logic [LEN_W-1:0]     chunk_bytes,
    output logic [AXI_LEN_W-1:0] beat_len,
    output logic                 last
);
    localparam int BEAT_SH   = $clog2(BEAT_BYTES);
    localparam int MAX_BYTES = AXI_MAX_BEATS * BEAT_BYTES;

    logic [12:0]      page_off;
    logic [12:0]      to_edge;
    logic [31:0]      pick;
    logic [LEN_W-1:0] beats;

    always_comb begin
        page_off    = page_1k ? {3'b000, addr_lo[9:0]} : {1'b0, addr_lo};
        to_edge     = (page_1k ? 13'(PAGE_SMALL) : 13'(PAGE_LARGE)) - page_off;
        pick        = umin(32'(rem_bytes), 32'(to_edge));
        pick        = umin(pick, 32'(MAX_BYTES));
        chunk_bytes = LEN_W'(pick);
        beats       = chunk_bytes >> BEAT_SH;
        beat_len    = AXI_LEN_W'(beats - 1'b1);
        last        = (chunk_bytes == rem_bytes);
    end
endmodule

// File: rtl/dma_outstanding_ctr.sv
module dma_outstanding_ctr
    import dma_split_pkg::*;
#(
    parameter int CNT_W = CFG_LIMIT_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   issue,
    input  logic                   rd_done,
    input  logic                   wr_done,
    input  logic [CFG_LIMIT_W-1:0] limit,
    output logic [CNT_W-1:0]       count,
    output logic                   room
);
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = count;
        if (issue)   cnt_d = cnt_d + CNT_W'(1);
        if (rd_done) cnt_d = cnt_d - CNT_W'(1);
        if (wr_done) cnt_d = cnt_d - CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= cnt_d;
    end

    assign room = (count <= CNT_W'(limit));
endmodule

// File: rtl/dma_burst_splitter.sv
module dma_burst_splitter
    import dma_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 24,
    parameter int BEAT_BYTES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [LEN_W-1:0]       req_len,
    input  logic                   req_write,
    input  logic                   cfg_page_1k,
    input  logic [CFG_LIMIT_W-1:0] cfg_limit,
    output logic                   ar_valid,
    input  logic                   ar_ready,
    output logic [ADDR_W-1:0]      ar_addr,
    output logic [AXI_LEN_W-1:0]   ar_len,
    output logic                   aw_valid,
    input  logic                   aw_ready,
    output logic [ADDR_W-1:0]      aw_addr,
    output logic [AXI_LEN_W-1:0]   aw_len,
    input  logic                   rd_last_done,
    input  logic                   wr_resp_done
);
    localparam int CNT_W = CFG_LIMIT_W + 1;

    split_state_e         state_q;
    cfg_snap_t            snap_q;
    logic [ADDR_W-1:0]    cur_addr_q;
    logic [LEN_W-1:0]     rem_q;
    logic                 is_wr_q;

    logic [LEN_W-1:0]     chunk;
    logic [AXI_LEN_W-1:0] beat_len;
    logic                 last_chunk;
    logic [CNT_W-1:0]     out_cnt;
    logic                 room;
    logic                 burst_up;
    logic                 burst_hs;
    logic                 accept;
    logic                 zero_ack;
    logic                 busy;

    dma_burst_calc #(
        .LEN_W      (LEN_W),
        .BEAT_BYTES (BEAT_BYTES)
    ) u_calc (
        .addr_lo     (cur_addr_q[11:0]),
        .rem_bytes   (rem_q),
        .page_1k     (snap_q.page_1k),
        .chunk_bytes (chunk),
        .beat_len    (beat_len),
        .last        (last_chunk)
    );

    dma_outstanding_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .issue   (burst_hs),
        .rd_done (rd_last_done),
        .wr_done (wr_resp_done),
        .limit   (snap_q.limit),
        .count   (out_cnt),
        .room    (room)
    );

    assign busy     = (state_q == ST_BUSY);
    assign accept   = !busy && req_valid && (req_len != '0);
    assign zero_ack = !busy && req_valid && (req_len == '0);
    assign burst_up = busy && room;

    assign ar_valid = burst_up && !is_wr_q;
    assign aw_valid = burst_up &&  is_wr_q;
    assign ar_addr  = cur_addr_q;
    assign aw_addr  = cur_addr_q;
    assign ar_len   = beat_len;
    assign aw_len   = beat_len;

    assign burst_hs  = (ar_valid && ar_ready) || (aw_valid && aw_ready);
    assign req_ready = zero_ack || (burst_hs && last_chunk);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            snap_q     <= CFG_RESET;
            cur_addr_q <= '0;
            rem_q      <= '0;
            is_wr_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q    <= ST_BUSY;
                        snap_q     <= '{page_1k: cfg_page_1k, limit: cfg_limit};
                        cur_addr_q <= req_addr;
                        rem_q      <= req_len;
                        is_wr_q    <= req_write;
                    end
                end
                ST_BUSY: begin
                    if (burst_hs) begin
                        cur_addr_q <= cur_addr_q + ADDR_W'(chunk);
                        rem_q      <= rem_q - chunk;
                        if (last_chunk) state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_split_checker.sv
module dma_split_checker
    import dma_split_pkg::*;
#(
    parameter int LEN_W      = 24,
    parameter int BEAT_BYTES = 8,
    parameter int CNT_W      = CFG_LIMIT_W + 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   req_valid,
    input logic                   req_ready,
    input logic [LEN_W-1:0]       req_len,
    input logic                   busy,
    input logic                   ar_valid,
    input logic                   ar_ready,
    input logic [11:0]            ar_addr_lo,
    input logic [AXI_LEN_W-1:0]   ar_len,
    input logic                   aw_valid,
    input logic                   aw_ready,
    input logic [11:0]            aw_addr_lo,
    input logic [AXI_LEN_W-1:0]   aw_len,
    input logic                   rd_last_done,
    input logic                   wr_resp_done,
    input logic [CNT_W-1:0]       out_cnt,
    input logic [CFG_LIMIT_W-1:0] lim,
    input logic                   page_1k
);
    localparam int BEAT_SH = $clog2(BEAT_BYTES);

    logic [11:0] sel_addr;
    logic [13:0] sel_bytes;
    logic [13:0] end_big;
    logic [13:0] end_small;
    logic        any_valid;
    logic        any_hs;

    always_comb begin
        sel_addr  = aw_valid ? aw_addr_lo : ar_addr_lo;
        sel_bytes = (14'(aw_valid ? aw_len : ar_len) + 14'd1) << BEAT_SH;
        end_big   = {2'b00, sel_addr} + sel_bytes;
        end_small = {4'b0000, sel_addr[9:0]} + sel_bytes;
        any_valid = ar_valid || aw_valid;
        any_hs    = (ar_valid && ar_ready) || (aw_valid && aw_ready);
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> !ar_valid && !aw_valid);

    a_r2_no_4k_cross: assert property (@(posedge clk) disable iff (rst)
        any_valid && !page_1k |-> end_big <= 14'd4096);

    a_r3_no_1k_cross: assert property (@(posedge clk) disable iff (rst)
        any_valid && page_1k |-> end_small <= 14'd1024);

    a_r5_one_channel: assert property (@(posedge clk) disable iff (rst)
        !(ar_valid && aw_valid));

    a_r6_ar_hold: assert property (@(posedge clk) disable iff (rst)
        ar_valid && !ar_ready |=> ar_valid && $stable(ar_addr_lo) && $stable(ar_len));

    a_r6_aw_hold: assert property (@(posedge clk) disable iff (rst)
        aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr_lo) && $stable(aw_len));

    a_r7_cap: assert property (@(posedge clk) disable iff (rst)
        out_cnt > CNT_W'(lim) |-> !any_valid);

    a_r8_count_up: assert property (@(posedge clk) disable iff (rst)
        any_hs && !rd_last_done && !wr_resp_done |=> out_cnt == $past(out_cnt) + CNT_W'(1));

    a_r9_zero_ack: assert property (@(posedge clk) disable iff (rst)
        req_valid && !busy && req_len == '0 |-> req_ready && !any_valid);

    a_r9_no_idle_ack: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> any_hs || req_len == '0);
endmodule

bind dma_burst_splitter dma_split_checker #(
    .LEN_W      (LEN_W),
    .BEAT_BYTES (BEAT_BYTES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_len      (req_len),
    .busy         (busy),
    .ar_valid     (ar_valid),
    .ar_ready     (ar_ready),
    .ar_addr_lo   (ar_addr[11:0]),
    .ar_len       (ar_len),
    .aw_valid     (aw_valid),
    .aw_ready     (aw_ready),
    .aw_addr_lo   (aw_addr[11:0]),
    .aw_len       (aw_len),
    .rd_last_done (rd_last_done),
    .wr_resp_done (wr_resp_done),
    .out_cnt      (out_cnt),
    .lim          (snap_q.limit),
    .page_1k      (snap_q.page_1k)
);

// File: tb/test_dma_burst_splitter.sv
module test_dma_burst_splitter;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_write = 1'b0;
    logic              cfg_page_1k = 1'b0;
    logic [3:0]        cfg_limit = 4'd15;
    logic              ar_valid, aw_valid;
    logic              ar_ready = 1'b1;
    logic              aw_ready = 1'b1;
    logic [ADDR_W-1:0] ar_addr, aw_addr;
    logic [7:0]        ar_len, aw_len;
    logic              rd_last_done = 1'b0;
    logic              wr_resp_done = 1'b0;

    int checks = 0;
    int errors = 0;
    int hs_total = 0;

    always #10 clk = ~clk;

    dma_burst_splitter i_dma_burst_splitter (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .cfg_page_1k(cfg_page_1k), .cfg_limit(cfg_limit),
        .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
        .rd_last_done(rd_last_done), .wr_resp_done(wr_resp_done)
    );

    always begin
        @(negedge clk);
        #2;
        if (!rst && ((ar_valid && ar_ready) || (aw_valid && aw_ready))) hs_total++;
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic drain(input int n, input bit use_wr);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (use_wr) wr_resp_done = 1'b1; else rd_last_done = 1'b1;
        end
        @(negedge clk);
        rd_last_done = 1'b0;
        wr_resp_done = 1'b0;
    endtask

    // Issue one transfer with ready held high; compare every burst with an
    // independently computed split (R2, R3, R4, R5, R9, R10).
    task automatic run_req(input logic [31:0] addr, input int len, input bit wr,
                           input bit pg1k, input bit flip, input string rq, output int nb);
        int rem, chunk, page, guard;
        logic [31:0] ea;
        bit done, hs;
        @(negedge clk);
        cfg_limit   = 4'd15;
        cfg_page_1k = pg1k;
        req_addr = addr; req_len = LEN_W'(len); req_write = wr; req_valid = 1'b1;
        ea = addr; rem = len; nb = 0; done = 0; guard = 0;
        page = pg1k ? 1024 : 4096;
        while (!done && guard < 2000) begin
            #2;
            hs = wr ? aw_valid : ar_valid;
            if (wr) chk(!ar_valid, "R5", "AR valid on write", ar_valid, 0);
            else    chk(!aw_valid, "R5", "AW valid on read", aw_valid, 0);
            if (hs) begin
                chunk = page - int'(ea % page);
                if (rem < chunk) chunk = rem;
                if (chunk > 2048) chunk = 2048;
                chk((wr ? aw_addr : ar_addr) == ea, rq, "burst address",
                    wr ? aw_addr : ar_addr, ea);
                chk((wr ? aw_len : ar_len) == 8'(chunk / 8 - 1), rq, "burst length",
                    wr ? aw_len : ar_len, chunk / 8 - 1);
                ea += 32'(chunk); rem -= chunk; nb++;
                if (flip && nb == 1) cfg_page_1k = !pg1k;
                chk(req_ready == (rem == 0), "R9", "ack vs last burst", req_ready, rem == 0);
            end else if (req_ready) begin
                chk(0, "R9", "ack without burst", 1, 0);
            end
            if (req_ready) done = 1;
            @(negedge clk);
            guard++;
        end
        chk(done, rq, "request acknowledged", done, 1);
        req_valid = 1'b0;
        cfg_page_1k = 1'b0;
    endtask

    task automatic t_reset();
        chk(!ar_valid && !aw_valid, "R1", "valid in reset", {ar_valid, aw_valid}, 0);
        @(negedge clk); rst = 1'b0; #2;
        chk(!ar_valid && !aw_valid, "R1", "valid after reset", {ar_valid, aw_valid}, 0);
        chk(!req_ready, "R1", "req_ready after reset", req_ready, 0);
    endtask

    task automatic t_single();
        int nb;
        run_req(32'h100, 64, 0, 0, 0, "R4", nb);
        chk(nb == 1, "R4", "single burst count", nb, 1);
        drain(nb, 0);
    endtask

    task automatic t_split_4k();
        int nb;
        run_req(32'h0000_0F00, 32'h300, 0, 0, 0, "R2", nb);
        chk(nb == 2, "R2", "4K split count", nb, 2);
        drain(nb, 0);
    endtask

    task automatic t_split_1k();
        int nb;
        run_req(32'h0000_53C0, 32'h100, 0, 1, 0, "R3", nb);
        chk(nb == 2, "R3", "1K split count", nb, 2);
        drain(nb, 0);
    endtask

    task automatic t_max_burst();
        int nb;
        run_req(32'h0001_0000, 4096, 0, 0, 0, "R4", nb);
        chk(nb == 2, "R4", "256-beat cap count", nb, 2);
        drain(nb, 0);
    endtask

    task automatic t_write();
        int nb;
        run_req(32'h0002_0FC0, 32'h80, 1, 0, 0, "R5", nb);
        chk(nb == 2, "R5", "write burst count", nb, 2);
        drain(nb, 1);
    endtask

    task automatic t_cfg_change();
        int nb;
        run_req(32'h0003_03C0, 32'h500, 0, 1, 1, "R10", nb);
        chk(nb == 3, "R10", "snapshot split count", nb, 3);
        drain(nb, 0);
    endtask

    task automatic t_zero_len();
        int base;
        @(negedge clk);
        base = hs_total;
        req_addr = 32'h400; req_len = '0; req_write = 1'b0; req_valid = 1'b1;
        #2;
        chk(req_ready, "R9", "zero-length ack", req_ready, 1);
        @(negedge clk); req_valid = 1'b0;
        repeat (4) @(negedge clk);
        #3;
        chk(hs_total == base, "R9", "zero-length bursts", hs_total - base, 0);
    endtask

    task automatic t_stall();
        @(negedge clk);
        cfg_limit = 4'd15; ar_ready = 1'b0;
        req_addr = 32'h2000; req_len = 24'd16; req_write = 1'b0; req_valid = 1'b1;
        @(negedge clk); #3;
        chk(ar_valid && ar_addr == 32'h2000 && ar_len == 8'd1, "R6", "first stalled burst",
            ar_addr, 32'h2000);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk); #3;
            chk(ar_valid && ar_addr == 32'h2000 && ar_len == 8'd1 && !req_ready, "R6",
                "burst held under backpressure", ar_addr, 32'h2000);
        end
        ar_ready = 1'b1; #1;
        chk(req_ready, "R9", "ack on released burst", req_ready, 1);
        @(negedge clk); req_valid = 1'b0;
        drain(1, 0);
    endtask

    task automatic t_limit();
        int base;
        bit acked;
        @(negedge clk);
        cfg_limit = 4'd1; cfg_page_1k = 1'b1; ar_ready = 1'b1;
        req_addr = 32'h0; req_len = 24'd4096; req_write = 1'b0; req_valid = 1'b1;
        base = hs_total;
        repeat (8) @(negedge clk);
        #3;
        chk(hs_total - base == 2, "R7", "bursts issued at cap 2", hs_total - base, 2);
        chk(!ar_valid, "R7", "valid low at cap", ar_valid, 0);
        rd_last_done = 1'b1;
        @(negedge clk); #3;
        chk(ar_valid, "R8", "valid after one completion", ar_valid, 1);
        @(negedge clk); rd_last_done = 1'b0; #3;
        chk(ar_valid && req_ready, "R8", "netted issue and completion", {ar_valid, req_ready}, 3);
        chk(hs_total - base == 4, "R8", "all four bursts issued", hs_total - base, 4);
        @(negedge clk); req_valid = 1'b0;
        rd_last_done = 1'b1; wr_resp_done = 1'b1;
        @(negedge clk); rd_last_done = 1'b0; wr_resp_done = 1'b0;
        req_addr = 32'h1_0000; req_len = 24'd3072; req_valid = 1'b1;
        base = hs_total;
        repeat (6) @(negedge clk);
        #3;
        chk(hs_total - base == 2, "R8", "double completion frees two slots", hs_total - base, 2);
        rd_last_done = 1'b1;
        @(negedge clk); rd_last_done = 1'b0;
        acked = 0;
        for (int i = 0; i < 10 && !acked; i++) begin
            #3;
            if (req_ready) acked = 1;
            @(negedge clk);
        end
        chk(acked, "R7", "third burst after release", acked, 1);
        req_valid = 1'b0; cfg_page_1k = 1'b0; cfg_limit = 4'd15;
        drain(2, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single();
        t_split_4k();
        t_split_1k();
        t_max_burst();
        t_write();
        t_cfg_change();
        t_zero_len();
        t_stall();
        t_limit();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule